// File: doc/BRIEF.md
# Snooping MSI Line Controller

This block manages a small direct-mapped, write-back data cache that shares a snooping bus with other caches. Each block holds one data word. Every line carries a coherence state (Invalid, Shared or Modified). The controller answers processor loads and stores locally when the state allows it. Otherwise it requests the bus and issues a read, a read-for-ownership, an invalidate or a victim write-back. It waits for the grant and for any memory data, and then it completes the access.

While the processor side is busy, a second lookup path watches requests from the other caches on the bus. That path has its own copy of the tags. When another cache wants a line this cache holds dirty, the controller pushes the dirty word out on a flush port in the next cycle. It then demotes the line to Shared or Invalid. A remote invalidate or ownership request drops a clean copy to Invalid.

The processor must hold its request steady until `cpu_ready` pulses. Memory and the requesting cache take flushed words directly from the flush port.

Top module: `msi_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid (line state code 00; Shared is 01, Modified is 10, and 11 never occurs). `cpu_ready`, `bus_req` and `flush_valid` are low, and the first load to any address misses.
- R2: A load that misses issues one bus request with `bus_op` 01 (read) at the load address. It returns the word that memory delivers with `mem_rvalid`, and it leaves the line Shared.
- R3: A load that hits a Shared or Modified line, or a store that hits a Modified line, raises `cpu_ready` in the same cycle as the request and issues no bus request. A load returns the stored word.
- R4: A store that hits a Shared line issues `bus_op` 11 (invalidate) at its address. After the grant it completes and leaves the line Modified.
- R5: A store that misses issues `bus_op` 10 (read for ownership) at its address. It merges the store data into the fetched word and leaves the line Modified.
- R6: A miss on an index whose resident line is Modified with another tag first issues `bus_op` 00 (write-back). That request carries the resident line's address and data, and the fill request follows it. A miss on a clean line issues no write-back.
- R7: A snooped `snp_op` 01 (read) that hits a Modified line raises `flush_valid` one cycle later, with the line address and dirty word. The line becomes Shared.
- R8: A snooped `snp_op` 10 (read for ownership) that hits a Modified line flushes the dirty word in the same way and leaves the line Invalid.
- R9: A snooped `snp_op` 11 (invalidate) or 10 that hits a Shared line leaves it Invalid, without a flush.
- R10: A snoop that misses (other tag or Invalid line), or one with `snp_op` 00, changes no line and raises no flush.
- R11: Once raised, `bus_req` keeps `bus_op` and `bus_addr` stable until `bus_gnt` arrives.
- R12: `cpu_ready` is high only while `cpu_req_valid` is high, and `flush_valid` is high only in the cycle after a snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req_valid | input | 1 | Processor request present, held until ready |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address of the request |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| bus_req | output | 1 | Bus request |
| bus_op | output | 2 | 00 write-back, 01 read, 10 read for ownership, 11 invalidate |
| bus_addr | output | ADDR_W | Bus request address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Bus grant, one cycle |
| mem_rvalid | input | 1 | Memory fill data valid |
| mem_rdata | input | DATA_W | Memory fill data |
| snp_valid | input | 1 | Remote bus request observed |
| snp_op | input | 2 | Remote operation, same encoding as bus_op |
| snp_addr | input | ADDR_W | Remote request address |
| flush_valid | output | 1 | Dirty word supplied for a remote request |
| flush_addr | output | ADDR_W | Address of flushed word |
| flush_data | output | DATA_W | Flushed dirty word |

## Verification
A wrong internal line state shows at the ports at the next access to that line. A line wrongly left Shared or Invalid produces an unexpected bus request on the next store or load. A line wrongly left Modified skips that request or flushes on the next remote read. So the bench follows every snoop and every fill with a processor access whose bus traffic reveals the state. A missing or stale flush appears one cycle after the snoop. A wrongly kept victim shows up as stale data after the refill.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_MOD = 2'b10
  } lstate_e;

  typedef enum logic [1:0] {
    BOP_WB  = 2'b00,
    BOP_RD  = 2'b01,
    BOP_RDX = 2'b10,
    BOP_INV = 2'b11
  } bop_e;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_WB,
    CS_FILL,
    CS_WAIT,
    CS_UPG
  } cstate_e;

  // State a line takes after a remote operation hits it.
  function automatic lstate_e snoop_next(lstate_e cur, bop_e op);
    case (op)
      BOP_RD:           return (cur == LS_MOD) ? LS_SHR : cur;
      BOP_RDX, BOP_INV: return LS_INV;
      default:          return cur;
    endcase
  endfunction

  // A dirty line must be pushed out when a remote cache reads it.
  function automatic logic snoop_flush(lstate_e cur, bop_e op);
    return (cur == LS_MOD) && ((op == BOP_RD) || (op == BOP_RDX));
  endfunction

  // State installed by a fill.
  function automatic lstate_e fill_state(logic is_store);
    return is_store ? LS_MOD : LS_SHR;
  endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  // processor side read
  input  logic [IDX_W-1:0]  c_idx,
  output logic [TAG_W-1:0]  c_tag,
  output lstate_e           c_state,
  output logic [DATA_W-1:0] c_data,
  // snoop side read
  input  logic [IDX_W-1:0]  s_idx,
  output lstate_e           s_state,
  output logic [DATA_W-1:0] s_data,
  // processor side write (fill, upgrade, store hit)
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  lstate_e           wr_state,
  input  logic [DATA_W-1:0] wr_data,
  // snoop side state update
  input  logic              st_en,
  input  logic [IDX_W-1:0]  st_idx,
  input  lstate_e           st_val,
  // flattened states for checking
  output logic [2*LINES-1:0] st_flat
);

  logic [TAG_W-1:0]  tag_q   [LINES];
  lstate_e           state_q [LINES];
  logic [DATA_W-1:0] data_q  [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i]   <= '0;
        state_q[i] <= LS_INV;
        data_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (wr_en && (wr_idx == IDX_W'(i))) begin
          tag_q[i]   <= wr_tag;
          state_q[i] <= wr_state;
          data_q[i]  <= wr_data;
        end else if (st_en && (st_idx == IDX_W'(i))) begin
          state_q[i] <= st_val;
        end
      end
    end
  end

  assign c_tag   = tag_q[c_idx];
  assign c_state = state_q[c_idx];
  assign c_data  = data_q[c_idx];
  assign s_state = state_q[s_idx];
  assign s_data  = data_q[s_idx];

  for (genvar g = 0; g < LINES; g++) begin : g_flat
    assign st_flat[2*g +: 2] = state_q[g];
  end

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINES  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  // mirror of the processor-side tag writes
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  // line store snoop port
  output logic [IDX_W-1:0]  s_idx,
  input  lstate_e           s_state,
  input  logic [DATA_W-1:0] s_data,
  output logic              st_en,
  output logic [IDX_W-1:0]  st_idx,
  output lstate_e           st_val,
  // flush port
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr,
  output logic [DATA_W-1:0] flush_data,
  // events
  output logic              ev_snp_hit,
  output logic              ev_snp_hit_mod
);

  logic [TAG_W-1:0] dup_tag_q [LINES];
  logic [TAG_W-1:0] s_tag;
  bop_e             op;
  lstate_e          nxt;
  logic             need_flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) dup_tag_q[i] <= '0;
    end else begin
      for (int i = 0; i < LINES; i++)
        if (wr_en && (wr_idx == IDX_W'(i))) dup_tag_q[i] <= wr_tag;
    end
  end

  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign op    = bop_e'(snp_op);

  assign ev_snp_hit     = snp_valid && (dup_tag_q[s_idx] == s_tag) && (s_state != LS_INV);
  assign ev_snp_hit_mod = ev_snp_hit && (s_state == LS_MOD);

  assign nxt        = snoop_next(s_state, op);
  assign need_flush = ev_snp_hit && snoop_flush(s_state, op);

  assign st_en  = ev_snp_hit && (nxt != s_state);
  assign st_idx = s_idx;
  assign st_val = nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_valid <= 1'b0;
      flush_addr  <= '0;
      flush_data  <= '0;
    end else begin
      flush_valid <= need_flush;
      if (need_flush) begin
        flush_addr <= snp_addr;
        flush_data <= s_data;
      end
    end
  end

endmodule

// File: rtl/msi_cpu_ctrl.sv
module msi_cpu_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LINES  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_write,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  // line store processor port
  output logic [IDX_W-1:0]  c_idx,
  input  logic [TAG_W-1:0]  c_tag,
  input  lstate_e           c_state,
  input  logic [DATA_W-1:0] c_data,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output lstate_e           wr_state,
  output logic [DATA_W-1:0] wr_data,
  // bus
  output logic              bus_req,
  output bop_e              bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  // events
  output logic              ev_idle,
  output logic              ev_rd_hit,
  output logic              ev_upgrade,
  output logic              ev_victim_wb
);

  cstate_e          cs_q, cs_d;
  logic [TAG_W-1:0] tag;
  logic             hit, rd_hit, wr_hit_m, upgrade, victim_dirty, still_shr;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign tag   = cpu_addr[ADDR_W-1:IDX_W];

  assign hit          = (c_tag == tag) && (c_state != LS_INV);
  assign rd_hit       = cpu_valid && !cpu_write && hit;
  assign wr_hit_m     = cpu_valid && cpu_write && hit && (c_state == LS_MOD);
  assign upgrade      = cpu_valid && cpu_write && hit && (c_state == LS_SHR);
  assign victim_dirty = !hit && (c_state == LS_MOD);
  assign still_shr    = (c_tag == tag) && (c_state == LS_SHR);

  assign ev_idle      = (cs_q == CS_IDLE);
  assign ev_rd_hit    = ev_idle && rd_hit;
  assign ev_upgrade   = ev_idle && upgrade;
  assign ev_victim_wb = ev_idle && cpu_valid && victim_dirty;

  assign cpu_rdata = c_data;

  always_comb begin
    cs_d      = cs_q;
    cpu_ready = 1'b0;
    bus_req   = 1'b0;
    bus_op    = BOP_RD;
    bus_addr  = cpu_addr;
    bus_wdata = '0;
    wr_en     = 1'b0;
    wr_idx    = c_idx;
    wr_tag    = tag;
    wr_state  = LS_INV;
    wr_data   = c_data;
    case (cs_q)
      CS_IDLE: begin
        if (cpu_valid) begin
          if (rd_hit) begin
            cpu_ready = 1'b1;
          end else if (wr_hit_m) begin
            cpu_ready = 1'b1;
            wr_en     = 1'b1;
            wr_state  = LS_MOD;
            wr_data   = cpu_wdata;
          end else if (upgrade) begin
            cs_d = CS_UPG;
          end else if (victim_dirty) begin
            cs_d = CS_WB;
          end else begin
            cs_d = CS_FILL;
          end
        end
      end
      CS_WB: begin
        if (c_state == LS_MOD) begin
          bus_req   = 1'b1;
          bus_op    = BOP_WB;
          bus_addr  = {c_tag, c_idx};
          bus_wdata = c_data;
          if (bus_gnt) begin
            wr_en    = 1'b1;
            wr_tag   = c_tag;
            wr_state = LS_SHR;
            cs_d     = CS_FILL;
          end
        end else begin
          cs_d = CS_FILL;
        end
      end
      CS_FILL: begin
        bus_req = 1'b1;
        bus_op  = cpu_write ? BOP_RDX : BOP_RD;
        if (bus_gnt) cs_d = CS_WAIT;
      end
      CS_WAIT: begin
        if (mem_rvalid) begin
          wr_en    = 1'b1;
          wr_state = fill_state(cpu_write);
          wr_data  = mem_rdata;
          cs_d     = CS_IDLE;
        end
      end
      CS_UPG: begin
        if (still_shr) begin
          bus_req = 1'b1;
          bus_op  = BOP_INV;
          if (bus_gnt) begin
            wr_en    = 1'b1;
            wr_state = LS_MOD;
            cs_d     = CS_IDLE;
          end
        end else begin
          cs_d = CS_IDLE;
        end
      end
      default: cs_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= CS_IDLE;
    else        cs_q <= cs_d;
  end

endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LINES  = 8,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              flush_valid,
  output logic [ADDR_W-1:0] flush_addr,
  output logic [DATA_W-1:0] flush_data
);

  logic [IDX_W-1:0]   c_idx, s_idx, wr_idx, st_idx;
  logic [TAG_W-1:0]   c_tag, wr_tag;
  lstate_e            c_state, s_state, wr_state, st_val;
  logic [DATA_W-1:0]  c_data, s_data, wr_data;
  logic               wr_en, st_en;
  bop_e               bus_op_e;
  logic [2*LINES-1:0] st_flat;
  logic               ev_idle, ev_rd_hit, ev_upgrade, ev_victim_wb;
  logic               ev_snp_hit, ev_snp_hit_mod;

  assign bus_op = bus_op_e;

  msi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .c_idx(c_idx), .c_tag(c_tag), .c_state(c_state), .c_data(c_data),
    .s_idx(s_idx), .s_state(s_state), .s_data(s_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_state(wr_state), .wr_data(wr_data),
    .st_en(st_en), .st_idx(st_idx), .st_val(st_val),
    .st_flat(st_flat)
  );

  msi_cpu_ctrl #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_cpu (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_req_valid), .cpu_write(cpu_req_write),
    .cpu_addr(cpu_req_addr), .cpu_wdata(cpu_req_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .c_idx(c_idx), .c_tag(c_tag), .c_state(c_state), .c_data(c_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_state(wr_state), .wr_data(wr_data),
    .bus_req(bus_req), .bus_op(bus_op_e), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ev_idle(ev_idle), .ev_rd_hit(ev_rd_hit), .ev_upgrade(ev_upgrade),
    .ev_victim_wb(ev_victim_wb)
  );

  msi_snoop_unit #(.ADDR_W(ADDR_W), .LINES(LINES), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
    .s_idx(s_idx), .s_state(s_state), .s_data(s_data),
    .st_en(st_en), .st_idx(st_idx), .st_val(st_val),
    .flush_valid(flush_valid), .flush_addr(flush_addr), .flush_data(flush_data),
    .ev_snp_hit(ev_snp_hit), .ev_snp_hit_mod(ev_snp_hit_mod)
  );

endmodule

// File: rtl/msi_cache_sva.sv
module msi_cache_sva #(
  parameter int ADDR_W = 16,
  parameter int LINES  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req_valid,
  input logic               cpu_ready,
  input logic               bus_req,
  input logic [1:0]         bus_op,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_gnt,
  input logic               snp_valid,
  input logic [1:0]         snp_op,
  input logic               flush_valid,
  input logic               ev_rd_hit,
  input logic               ev_upgrade,
  input logic               ev_victim_wb,
  input logic               ev_snp_hit,
  input logic               ev_snp_hit_mod,
  input logic [2*LINES-1:0] st_flat
);

  function automatic logic any_illegal(logic [2*LINES-1:0] v);
    logic bad;
    bad = 1'b0;
    for (int i = 0; i < LINES; i++) bad = bad | (v[2*i +: 2] == 2'b11);
    return bad;
  endfunction

  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !any_illegal(st_flat));

  p_hit_local_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rd_hit |-> cpu_ready && !bus_req);

  p_upgrade_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_upgrade && !snp_valid |=> bus_req && (bus_op == 2'b11));

  p_victim_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_victim_wb && !snp_valid |=> bus_req && (bus_op == 2'b00));

  p_flush_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_snp_hit_mod && (snp_op == 2'b01) |=> flush_valid);

  p_flush_rdx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_snp_hit_mod && (snp_op == 2'b10) |=> flush_valid);

  p_no_flush_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !ev_snp_hit |=> !flush_valid);

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> !bus_req || ($stable(bus_op) && $stable(bus_addr)));

  p_ready_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_req_valid);

  p_flush_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> $past(snp_valid));

endmodule

bind msi_cache_ctrl msi_cache_sva #(.ADDR_W(ADDR_W), .LINES(LINES)) u_sva (
  .clk(clk), .rst_n(rst_n),
  .cpu_req_valid(cpu_req_valid), .cpu_ready(cpu_ready),
  .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
  .snp_valid(snp_valid), .snp_op(snp_op), .flush_valid(flush_valid),
  .ev_rd_hit(ev_rd_hit), .ev_upgrade(ev_upgrade), .ev_victim_wb(ev_victim_wb),
  .ev_snp_hit(ev_snp_hit), .ev_snp_hit_mod(ev_snp_hit_mod),
  .st_flat(st_flat)
);

// File: tb/tb_msi_cache_ctrl.sv
module tb_msi_cache_ctrl;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [1:0] OP_WB = 2'b00, OP_RD = 2'b01, OP_RDX = 2'b10, OP_INV = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic [1:0]    bus_op;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_op = 2'b00;
  logic [AW-1:0] snp_addr = '0;
  logic          flush_valid;
  logic [AW-1:0] flush_addr;
  logic [DW-1:0] flush_data;

  always #10 clk = ~clk;

  msi_cache_ctrl dut (.*);

  int n_tests = 0, n_fail = 0;
  logic [DW-1:0] mem [256];
  int            n_ops = 0;
  logic [1:0]    log_op   [8];
  logic [AW-1:0] log_addr [8];
  logic [DW-1:0] log_data [8];
  int            gnt_delay = 0;
  int            hold_err = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    n_ops = 0;
  endtask

  // bus arbiter and memory model
  initial begin
    logic [1:0]    op;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    forever begin
      @(negedge clk);
      if (rst_n && bus_req) begin
        op = bus_op; a = bus_addr; d = bus_wdata;
        for (int k = 0; k < gnt_delay; k++) begin
          @(negedge clk);
          if (!bus_req || bus_op != op || bus_addr != a) hold_err++;
        end
        if (n_ops < 8) begin
          log_op[n_ops] = op; log_addr[n_ops] = a; log_data[n_ops] = d;
        end
        n_ops++;
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        if (op == OP_WB) mem[a[7:0]] = d;
        if (op == OP_RD || op == OP_RDX) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem[a[7:0]];
          @(negedge clk);
          mem_rvalid = 1'b0;
        end
      end
    end
  end

  // memory takes flushed words
  initial forever begin
    @(negedge clk);
    if (flush_valid) mem[flush_addr[7:0]] = flush_data;
  end

  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        output logic [DW-1:0] rd, output int cyc);
    @(posedge clk); #1;
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    cyc = 0; rd = '0;
    while (cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (cpu_ready) begin
        rd = cpu_rdata;
        break;
      end
    end
    @(posedge clk); #1;
    cpu_req_valid = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a,
                       output logic fv, output logic [AW-1:0] fa, output logic [DW-1:0] fd);
    @(posedge clk); #1;
    snp_valid = 1'b1; snp_op = op; snp_addr = a;
    @(posedge clk); #1;
    snp_valid = 1'b0;
    fv = flush_valid; fa = flush_addr; fd = flush_data;
  endtask

  localparam logic [AW-1:0] A_ADDR = 16'h0010, C_ADDR = 16'h0021,
                            C_ALT = 16'h0029, D_ADDR = 16'h0032, E_ADDR = 16'h0044;

  logic [DW-1:0] rd;
  int            cyc;
  logic          fv;
  logic [AW-1:0] fa;
  logic [DW-1:0] fd;

  task automatic t_reset();
    chk(cpu_ready == 0, "R1", "ready after reset", 32'(cpu_ready), 0);
    chk(bus_req == 0, "R1", "bus_req after reset", 32'(bus_req), 0);
    chk(flush_valid == 0, "R1", "flush after reset", 32'(flush_valid), 0);
  endtask

  task automatic t_read_miss();
    clear_log();
    access(0, A_ADDR, 0, rd, cyc);
    chk(n_ops == 1 && log_op[0] == OP_RD, "R1", "first load misses with read", 32'(n_ops), 1);
    chk(log_addr[0] == A_ADDR, "R2", "read address", 32'(log_addr[0]), 32'(A_ADDR));
    chk(rd == 32'hA000_0010, "R2", "fill data", rd, 32'hA000_0010);
  endtask

  task automatic t_read_hit();
    clear_log();
    access(0, A_ADDR, 0, rd, cyc);
    chk(n_ops == 0 && cyc == 1, "R3", "shared load hit local in one cycle", 32'(cyc), 1);
    chk(rd == 32'hA000_0010, "R3", "shared hit data", rd, 32'hA000_0010);
  endtask

  task automatic t_upgrade();
    clear_log();
    access(1, A_ADDR, 32'h1111, rd, cyc);
    chk(n_ops == 1 && log_op[0] == OP_INV && log_addr[0] == A_ADDR, "R4",
        "store to shared sends invalidate", 32'(log_op[0]), 32'(OP_INV));
    clear_log();
    access(0, A_ADDR, 0, rd, cyc);
    chk(n_ops == 0 && cyc == 1 && rd == 32'h1111, "R3", "modified load hit", rd, 32'h1111);
    clear_log();
    access(1, A_ADDR, 32'h2222, rd, cyc);
    chk(n_ops == 0 && cyc == 1, "R3", "modified store hit silent", 32'(n_ops), 0);
  endtask

  task automatic t_snoop_rd();
    snoop(OP_RD, A_ADDR, fv, fa, fd);
    chk(fv && fa == A_ADDR && fd == 32'h2222, "R7", "flush on remote read", fd, 32'h2222);
    clear_log();
    access(1, A_ADDR, 32'h3333, rd, cyc);
    chk(n_ops == 1 && log_op[0] == OP_INV, "R7", "line demoted to shared", 32'(log_op[0]), 32'(OP_INV));
  endtask

  task automatic t_snoop_rdx();
    snoop(OP_RDX, A_ADDR, fv, fa, fd);
    chk(fv && fa == A_ADDR && fd == 32'h3333, "R8", "flush on remote ownership", fd, 32'h3333);
    clear_log();
    access(0, A_ADDR, 0, rd, cyc);
    chk(n_ops == 1 && log_op[0] == OP_RD, "R8", "line invalid after ownership", 32'(n_ops), 1);
    chk(rd == 32'h3333, "R8", "memory holds flushed word", rd, 32'h3333);
  endtask

  task automatic t_snoop_shared();
    snoop(OP_INV, A_ADDR, fv, fa, fd);
    chk(fv == 0, "R9", "no flush on invalidate of shared", 32'(fv), 0);
    clear_log();
    access(0, A_ADDR, 0, rd, cyc);
    chk(n_ops == 1 && log_op[0] == OP_RD, "R9", "shared line invalidated", 32'(n_ops), 1);
    snoop(OP_RDX, A_ADDR, fv, fa, fd);
    chk(fv == 0, "R9", "no flush on ownership of shared", 32'(fv), 0);
    clear_log();
    access(0, A_ADDR, 0, rd, cyc);
    chk(n_ops == 1 && log_op[0] == OP_RD, "R9", "shared line dropped by ownership", 32'(n_ops), 1);
  endtask

  task automatic t_write_miss();
    clear_log();
    access(1, C_ADDR, 32'h5555, rd, cyc);
    chk(n_ops == 1 && log_op[0] == OP_RDX && log_addr[0] == C_ADDR, "R5",
        "store miss uses ownership read", 32'(log_op[0]), 32'(OP_RDX));
    clear_log();
    access(0, C_ADDR, 0, rd, cyc);
    chk(n_ops == 0 && rd == 32'h5555, "R5", "store merged, line modified", rd, 32'h5555);
  endtask

  task automatic t_snoop_ignore();
    snoop(OP_RD, C_ALT, fv, fa, fd);
    chk(fv == 0, "R10", "other tag ignored", 32'(fv), 0);
    snoop(OP_WB, C_ADDR, fv, fa, fd);
    chk(fv == 0, "R10", "write-back op ignored", 32'(fv), 0);
    snoop(OP_RDX, D_ADDR, fv, fa, fd);
    chk(fv == 0, "R10", "invalid line ignored", 32'(fv), 0);
    clear_log();
    access(1, C_ADDR, 32'h6666, rd, cyc);
    chk(n_ops == 0 && cyc == 1, "R10", "line still modified", 32'(n_ops), 0);
  endtask

  task automatic t_victim();
    clear_log();
    access(0, C_ALT, 0, rd, cyc);
    chk(n_ops == 2 && log_op[0] == OP_WB && log_addr[0] == C_ADDR, "R6",
        "dirty victim written back first", 32'(log_op[0]), 32'(OP_WB));
    chk(log_data[0] == 32'h6666 && log_op[1] == OP_RD && log_addr[1] == C_ALT, "R6",
        "victim data then fill", log_data[0], 32'h6666);
    chk(rd == 32'hA000_0029, "R6", "new line data", rd, 32'hA000_0029);
    clear_log();
    access(0, C_ADDR, 0, rd, cyc);
    chk(n_ops == 1 && log_op[0] == OP_RD && rd == 32'h6666, "R6",
        "clean victim not written back", 32'(n_ops), 1);
  endtask

  task automatic t_hold();
    gnt_delay = 3; hold_err = 0;
    clear_log();
    access(0, E_ADDR, 0, rd, cyc);
    gnt_delay = 0;
    chk(hold_err == 0, "R11", "request stable until grant", 32'(hold_err), 0);
    chk(cyc >= 6 && rd == 32'hA000_0044, "R11", "delayed grant completes", rd, 32'hA000_0044);
  endtask

  task automatic t_quiet();
    int bad;
    bad = 0;
    repeat (4) begin
      @(negedge clk);
      if (cpu_ready || flush_valid) bad++;
    end
    chk(bad == 0, "R12", "ready and flush quiet without cause", 32'(bad), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + 32'(i);
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_read_miss();
    t_read_hit();
    t_upgrade();
    t_snoop_rd();
    t_snoop_rdx();
    t_snoop_shared();
    t_write_miss();
    t_snoop_ignore();
    t_victim();
    t_hold();
    t_quiet();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule